// File: doc/BRIEF.md
# Serial Flash Command Front End

This block sits at the command side of a small serial flash slave. It frames instructions that arrive on an SPI mode 0 link (chip select, serial clock, data in, data out), decodes the first byte as an opcode and keeps the write-enable latch. It also holds an 8-bit status word whose lowest bit shows that an internal cycle is running. Commands commit when chip select returns high, and only if the frame carried whole bytes in the length that command needs.

Program, block erase, chip erase and status-write commands go ahead only while the write-enable latch is set. An accepted program or erase sends a one-cycle start pulse with a kind code to the memory back end. For every accepted modifying command, a countdown holds the busy bit for a number of system clocks set by a parameter. When that countdown ends, busy drops and the latch clears. The status word can be polled during that time: while chip select stays low after the read-status opcode, the word is sent again and again, and its value is refreshed at the start of every byte.

The SPI pins are expected to be synchronous to `clk` and to change no more often than every other `clk` cycle. The block finds serial clock edges by comparing each pin with its value on the previous cycle.

Top module: `sflash_cmd_front`

## Requirements
- R1: A frame of exactly one whole byte 0x06 (write enable) sets the write-enable latch when chip select rises.
- R2: A frame of exactly one whole byte 0x04 (write disable) clears the write-enable latch when chip select rises.
- R3: Status write (0x01), program (0x02), block erase (0xD8) and chip erase (0xC7) are ignored while the latch is 0: no start pulse, no status change, no busy.
- R4: A frame that ends part-way through a byte, or whose byte count does not fit its opcode, is discarded. The counts are: 1 byte for 0x06, 0x04 and 0xC7; 2 for 0x01; ADDR_BYTES+1 for 0xD8; at least ADDR_BYTES+2 for 0x02.
- R5: The latch is 0 after reset, and it clears on the same clock edge on which a status-write, program or erase cycle ends.
- R6: The status word is {user[5:0], latch, busy}, with busy at bit 0 and the latch at bit 1. Bits 7:2 are loaded from bits 7:2 of the status-write data byte, and bits 1:0 ignore that byte. After reset the word reads 0x00.
- R7: After opcode 0x05, the status word is driven on data out, MSB first. Each bit changes on a falling serial clock edge, so it is valid at the next rising edge. The word repeats for as long as chip select stays low, and its value is taken afresh at every byte boundary, also while busy. Data out is 0 while chip select is high.
- R8: An accepted status write, program or erase sets busy for T_WRSR, T_PP, T_BE or T_CE clock cycles. An accepted program, block erase or chip erase pulses `op_start` for one cycle with `op_kind` 0, 1 or 2.
- R9: While busy is 1, every command except read status is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, idle low |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block |
| op_start | output | 1 | One-cycle pulse that starts a program or erase in the back end |
| op_kind | output | 2 | Kind of started job: 0 program, 1 block erase, 2 chip erase |

## Verification
The bench builds the block with busy times of 300, 400, 500 and 600 clocks and a serial half period of four clocks. Each busy window then spans several status bytes. One read-status frame can show busy set on every byte, a later frame can show it cleared, and a command sent during the window meets the busy lockout. The address length keeps its default of three bytes, so the block-erase and program length rules are tested at four and five bytes, one byte away from a wrong length.

// File: rtl/sfc_pkg.sv
// Shared opcodes, status bit positions and job codes for the serial flash
// command front end. Assumes opcodes arrive MSB first.
package sfc_pkg;
    localparam logic [7:0] OPC_WREN = 8'h06;
    localparam logic [7:0] OPC_WRDI = 8'h04;
    localparam logic [7:0] OPC_RDSR = 8'h05;
    localparam logic [7:0] OPC_WRSR = 8'h01;
    localparam logic [7:0] OPC_PP   = 8'h02;
    localparam logic [7:0] OPC_BE   = 8'hD8;
    localparam logic [7:0] OPC_CE   = 8'hC7;

    localparam int ST_BUSY = 0;
    localparam int ST_WEL  = 1;

    typedef enum logic [1:0] {
        JOB_PROG      = 2'd0,
        JOB_BLKERASE  = 2'd1,
        JOB_CHIPERASE = 2'd2,
        JOB_STATUS    = 2'd3
    } job_e;
endpackage

// File: rtl/sfc_link.sv
// Serial link framer: finds serial clock and chip select edges by comparing
// each pin with its previous-cycle value, shifts in bytes on rising serial
// clock, counts whole bytes, and replays the status word on falling edges
// after a read-status opcode. Assumes pins synchronous to clk.
module sfc_link #(
    parameter int NB_MAX = 5,
    localparam int NB_W = $clog2(NB_MAX + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            sck,
    input  logic            mosi,
    input  logic [7:0]      status_in,
    output logic            miso,
    output logic            fr_end,
    output logic [7:0]      fr_opcode,
    output logic [5:0]      fr_data_hi,
    output logic [NB_W-1:0] fr_nbytes,
    output logic            fr_aligned
);
    import sfc_pkg::*;

    logic            sck_q, cs_q;
    logic [2:0]      bit_cnt;
    logic [6:0]      rx_sr;
    logic [7:0]      tx_sr;
    logic [NB_W-1:0] nbytes_q;
    logic [7:0]      opcode_q;
    logic [5:0]      data_q;
    logic            rdsr_act;
    logic            miso_q;
    logic            sck_rise, sck_fall;
    logic [7:0]      new_byte;

    // Edge events on the serial clock within a frame.
    always_comb begin
        sck_rise = sck & ~sck_q & ~cs_n;
        sck_fall = ~sck & sck_q & ~cs_n;
        new_byte = {rx_sr, mosi};
    end

    // Previous-cycle copies of the pins for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
        end
    end

    // Receive shifter, byte counter, opcode and data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_sr    <= '0;
            nbytes_q <= '0;
            opcode_q <= '0;
            data_q   <= '0;
            rdsr_act <= 1'b0;
        end else if (cs_n) begin
            bit_cnt  <= '0;
            nbytes_q <= '0;
            rdsr_act <= 1'b0;
        end else if (sck_rise) begin
            rx_sr   <= new_byte[6:0];
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
                if (nbytes_q != NB_W'(NB_MAX))
                    nbytes_q <= nbytes_q + NB_W'(1);
                if (nbytes_q == '0) begin
                    opcode_q <= new_byte;
                    rdsr_act <= (new_byte == OPC_RDSR);
                end
                if (nbytes_q == NB_W'(1))
                    data_q <= new_byte[7:2];
            end
        end
    end

    // Transmit path: reload status at each byte boundary, else shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr  <= '0;
            miso_q <= 1'b0;
        end else if (cs_n) begin
            miso_q <= 1'b0;
        end else if (sck_fall && rdsr_act) begin
            if (bit_cnt == 3'd0) begin
                miso_q <= status_in[7];
                tx_sr  <= {status_in[6:0], 1'b0};
            end else begin
                miso_q <= tx_sr[7];
                tx_sr  <= {tx_sr[6:0], 1'b0};
            end
        end
    end

    assign miso       = miso_q;
    assign fr_end     = cs_n & ~cs_q;
    assign fr_opcode  = opcode_q;
    assign fr_data_hi = data_q;
    assign fr_nbytes  = nbytes_q;
    assign fr_aligned = (bit_cnt == 3'd0);
endmodule

// File: rtl/sfc_busy_timer.sv
// Busy countdown: loads a cycle count and decrements to zero. Busy while
// non-zero; done is high in the last busy cycle. Assumes load values >= 1.
module sfc_busy_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    // Countdown register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - CNT_W'(1);
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CNT_W'(1));
endmodule

// File: rtl/sfc_ctrl.sv
// Command control: decodes each completed frame, keeps the write-enable
// latch and user status bits, starts the busy timer and issues start pulses
// to the back end. Assumes frame info is valid in the fr_end cycle.
module sfc_ctrl #(
    parameter int ADDR_BYTES = 3,
    parameter int NB_W       = 3,
    parameter int CNT_W      = 8,
    parameter int T_WRSR     = 10,
    parameter int T_PP       = 10,
    parameter int T_BE       = 10,
    parameter int T_CE       = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fr_end,
    input  logic [7:0]       fr_opcode,
    input  logic [5:0]       fr_data_hi,
    input  logic [NB_W-1:0]  fr_nbytes,
    input  logic             fr_aligned,
    input  logic             busy,
    input  logic             done,
    output logic [7:0]       status,
    output logic             wel,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             op_start,
    output logic [1:0]       op_kind
);
    import sfc_pkg::*;

    logic       wel_q, set_wel, clr_wel, launch, wr_user;
    logic [5:0] user_q;
    logic       op_start_q;
    logic [1:0] op_kind_q;
    job_e       job;
    logic       len1, len2, len_be, len_pp;

    // Frame length classes.
    always_comb begin
        len1   = fr_aligned && (fr_nbytes == NB_W'(1));
        len2   = fr_aligned && (fr_nbytes == NB_W'(2));
        len_be = fr_aligned && (fr_nbytes == NB_W'(ADDR_BYTES + 1));
        len_pp = fr_aligned && (fr_nbytes >= NB_W'(ADDR_BYTES + 2));
    end

    // Opcode decode at chip-select release; nothing but read status while busy.
    always_comb begin
        set_wel = 1'b0;
        clr_wel = 1'b0;
        launch  = 1'b0;
        wr_user = 1'b0;
        job     = JOB_STATUS;
        if (fr_end && !busy) begin
            case (fr_opcode)
                OPC_WREN: set_wel = len1;
                OPC_WRDI: clr_wel = len1;
                OPC_WRSR: begin
                    launch  = len2 && wel_q;
                    wr_user = len2 && wel_q;
                    job     = JOB_STATUS;
                end
                OPC_PP: begin
                    launch = len_pp && wel_q;
                    job    = JOB_PROG;
                end
                OPC_BE: begin
                    launch = len_be && wel_q;
                    job    = JOB_BLKERASE;
                end
                OPC_CE: begin
                    launch = len1 && wel_q;
                    job    = JOB_CHIPERASE;
                end
                default: ;
            endcase
        end
    end

    // Busy duration per job kind.
    always_comb begin
        case (job)
            JOB_PROG:      tmr_val = CNT_W'(T_PP);
            JOB_BLKERASE:  tmr_val = CNT_W'(T_BE);
            JOB_CHIPERASE: tmr_val = CNT_W'(T_CE);
            default:       tmr_val = CNT_W'(T_WRSR);
        endcase
    end

    // Write-enable latch: completion and disable win over enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wel_q <= 1'b0;
        else if (done || clr_wel)
            wel_q <= 1'b0;
        else if (set_wel)
            wel_q <= 1'b1;
    end

    // User-writable status bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            user_q <= '0;
        else if (wr_user)
            user_q <= fr_data_hi;
    end

    // Back-end start pulse and job kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_start_q <= 1'b0;
            op_kind_q  <= '0;
        end else begin
            op_start_q <= launch && (job != JOB_STATUS);
            if (launch)
                op_kind_q <= 2'(job);
        end
    end

    always_comb begin
        status          = {user_q, 2'b00};
        status[ST_WEL]  = wel_q;
        status[ST_BUSY] = busy;
    end

    assign wel      = wel_q;
    assign tmr_load = launch;
    assign op_start = op_start_q;
    assign op_kind  = op_kind_q;
endmodule

// File: rtl/sflash_cmd_front.sv
// Top of the serial flash command front end: joins the serial link framer,
// the command control and the busy countdown. Assumes SPI pins synchronous
// to clk with at least two clk cycles between serial clock edges.
module sflash_cmd_front #(
    parameter int ADDR_BYTES = 3,
    parameter int T_WRSR     = 5000,
    parameter int T_PP       = 20000,
    parameter int T_BE       = 200000,
    parameter int T_CE       = 1000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       mosi,
    output logic       miso,
    output logic       op_start,
    output logic [1:0] op_kind
);
    localparam int NB_MAX = ADDR_BYTES + 2;
    localparam int NB_W   = $clog2(NB_MAX + 1);
    localparam int T_A    = (T_WRSR > T_PP) ? T_WRSR : T_PP;
    localparam int T_B    = (T_BE > T_CE) ? T_BE : T_CE;
    localparam int T_MAX  = (T_A > T_B) ? T_A : T_B;
    localparam int CNT_W  = $clog2(T_MAX + 1);

    logic [7:0]       status_w;
    logic             fr_end_w, fr_aligned_w;
    logic [7:0]       fr_opcode_w;
    logic [5:0]       fr_data_hi_w;
    logic [NB_W-1:0]  fr_nbytes_w;
    logic             busy_w, done_w, wel_w, tmr_load_w;
    logic [CNT_W-1:0] tmr_val_w;

    sfc_link #(.NB_MAX(NB_MAX)) u_link (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .status_in(status_w), .miso(miso), .fr_end(fr_end_w),
        .fr_opcode(fr_opcode_w), .fr_data_hi(fr_data_hi_w),
        .fr_nbytes(fr_nbytes_w), .fr_aligned(fr_aligned_w)
    );

    sfc_ctrl #(
        .ADDR_BYTES(ADDR_BYTES), .NB_W(NB_W), .CNT_W(CNT_W),
        .T_WRSR(T_WRSR), .T_PP(T_PP), .T_BE(T_BE), .T_CE(T_CE)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .fr_end(fr_end_w), .fr_opcode(fr_opcode_w),
        .fr_data_hi(fr_data_hi_w), .fr_nbytes(fr_nbytes_w),
        .fr_aligned(fr_aligned_w), .busy(busy_w), .done(done_w),
        .status(status_w), .wel(wel_w), .tmr_load(tmr_load_w),
        .tmr_val(tmr_val_w), .op_start(op_start), .op_kind(op_kind)
    );

    sfc_busy_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load_w), .load_val(tmr_val_w),
        .busy(busy_w), .done(done_w)
    );
endmodule

// File: rtl/sfc_checker.sv
// Protocol checker for the command front end, bound into the top module.
module sfc_checker (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic miso,
    input logic op_start,
    input logic wel,
    input logic busy,
    input logic fr_end
);
    assert_wel_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> ($past(fr_end) && !$past(busy)));

    assert_wel_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wel) |-> ($past(fr_end) || $fell(busy)));

    assert_start_needs_wel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> $past(wel));

    assert_wel_clear_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);

    assert_miso_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> !miso);

    assert_busy_on_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> busy);

    assert_no_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> !$past(busy));
endmodule

bind sflash_cmd_front sfc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso(miso), .op_start(op_start),
    .wel(wel_w), .busy(busy_w), .fr_end(fr_end_w)
);

// File: tb/tb_sflash_cmd_front.sv
module tb_sflash_cmd_front;
    localparam int CLK_PERIOD = 10;
    localparam int HP = 4;
    localparam int T_WRSR = 300, T_PP = 400, T_BE = 500, T_CE = 600;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic miso, op_start;
    logic [1:0] op_kind;

    always #(CLK_PERIOD/2) clk = ~clk;

    sflash_cmd_front #(.ADDR_BYTES(3), .T_WRSR(T_WRSR), .T_PP(T_PP),
                       .T_BE(T_BE), .T_CE(T_CE)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .miso(miso), .op_start(op_start), .op_kind(op_kind)
    );

    int n_cmp = 0, n_bad = 0;
    bit finished = 1'b0;
    logic [7:0] exp_st_q[$];
    logic [7:0] got_st_q[$];
    string      st_tag_q[$];
    logic [1:0] exp_op_q[$];
    string      op_tag_q[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_low();
        cs_n = 1'b0;
        tick(HP);
    endtask

    task automatic cs_high();
        tick(HP);
        cs_n = 1'b1;
        tick(4*HP);
    endtask

    task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 0; i < n; i++) begin
            mosi = tx[7-i];
            tick(HP);
            rx[7-i] = miso;
            sck = 1'b1;
            tick(HP);
            sck = 1'b0;
        end
    endtask

    task automatic xbyte(input logic [7:0] tx);
        logic [7:0] rx;
        xbits(tx, 8, rx);
    endtask

    task automatic cmd1(input logic [7:0] op);
        cs_low();
        xbyte(op);
        cs_high();
    endtask

    // Driver: queue expected status bytes, then read them over the link.
    task automatic rdsr(input int n, input logic [7:0] exp, input string tag);
        logic [7:0] rx;
        cs_low();
        xbyte(8'h05);
        for (int k = 0; k < n; k++) begin
            exp_st_q.push_back(exp);
            st_tag_q.push_back(tag);
            xbits(8'h00, 8, rx);
            got_st_q.push_back(rx);
        end
        cs_high();
    endtask

    // Monitor: compare read-back status bytes against the expected queue.
    initial begin
        forever begin
            @(negedge clk);
            while (got_st_q.size() > 0 && exp_st_q.size() > 0) begin
                logic [7:0] g, e;
                string t;
                g = got_st_q.pop_front();
                e = exp_st_q.pop_front();
                t = st_tag_q.pop_front();
                check(g == e, t, g, e);
            end
        end
    end

    // Monitor: every start pulse must match a queued expected job kind.
    always @(negedge clk) begin
        if (rst_n && op_start) begin
            if (exp_op_q.size() == 0) begin
                check(1'b0, "R3 unexpected op_start", op_kind, 0);
            end else begin
                logic [1:0] e;
                string t;
                e = exp_op_q.pop_front();
                t = op_tag_q.pop_front();
                check(op_kind == e, t, op_kind, e);
            end
        end
    end

    initial begin
        logic [7:0] rx;
        tick(5);
        rst_n = 1'b1;
        tick(4);

        rdsr(1, 8'h00, "R6 reset status");
        cmd1(8'h06);
        rdsr(1, 8'h02, "R1 write enable");
        cmd1(8'h04);
        rdsr(1, 8'h00, "R2 write disable");

        // R3: modifying commands without the latch
        cs_low(); xbyte(8'h01); xbyte(8'hFC); cs_high();
        rdsr(1, 8'h00, "R3 status write blocked");
        cs_low(); xbyte(8'h02); xbyte(8'h00); xbyte(8'h00); xbyte(8'h00); xbyte(8'h11); cs_high();
        cmd1(8'hC7);
        rdsr(1, 8'h00, "R3 program/erase blocked");

        // R4: partial byte and wrong length
        cs_low(); xbits(8'h06, 5, rx); cs_high();
        rdsr(1, 8'h00, "R4 partial frame");
        cs_low(); xbyte(8'h06); xbyte(8'h00); cs_high();
        rdsr(1, 8'h00, "R4 long enable frame");

        // R6/R7/R8: status write, polled while busy
        cmd1(8'h06);
        cs_low(); xbyte(8'h01); xbyte(8'hB5); cs_high();
        rdsr(3, 8'hB7, "R7 repeated read while busy");
        tick(T_WRSR + 50);
        rdsr(1, 8'hB4, "R5 latch cleared after status write");

        // R4/R8: block erase lengths
        cmd1(8'h06);
        cs_low(); xbyte(8'hD8); xbyte(8'h00); cs_high();
        rdsr(1, 8'hB6, "R4 short block erase");
        exp_op_q.push_back(2'd1); op_tag_q.push_back("R8 block erase kind");
        cs_low(); xbyte(8'hD8); xbyte(8'h01); xbyte(8'h02); xbyte(8'h03); cs_high();
        rdsr(1, 8'hB7, "R8 busy during erase");
        tick(T_BE + 50);
        rdsr(1, 8'hB4, "R5 latch cleared after erase");

        // R9: program, then a status write during busy must be ignored
        cmd1(8'h06);
        exp_op_q.push_back(2'd0); op_tag_q.push_back("R8 program kind");
        cs_low(); xbyte(8'h02); xbyte(8'h00); xbyte(8'h10); xbyte(8'h20); xbyte(8'h5A); cs_high();
        cs_low(); xbyte(8'h01); xbyte(8'h00); cs_high();
        rdsr(1, 8'hB7, "R9 busy program");
        tick(T_PP + 50);
        rdsr(1, 8'hB4, "R9 status write ignored while busy");

        // Chip erase
        cmd1(8'h06);
        exp_op_q.push_back(2'd2); op_tag_q.push_back("R8 chip erase kind");
        cmd1(8'hC7);
        cmd1(8'h04);
        rdsr(1, 8'hB7, "R9 disable ignored while busy");
        tick(T_CE + 50);
        rdsr(1, 8'hB4, "R5 latch cleared after chip erase");

        tick(20);
        check(exp_op_q.size() == 0, "R8 missing op_start", exp_op_q.size(), 0);
        check(exp_st_q.size() == 0, "R7 missing status bytes", exp_st_q.size(), 0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (R1..R9 run incomplete): actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule